// File: doc/BRIEF.md
# XOR-Sequenced Shuffle-Exchange Lane Permuter

This block moves N equal-width data lanes through log2 N identical layers. Each layer has a column of 2x2 exchange cells that work on neighbouring lane pairs, followed by a fixed perfect-shuffle wiring. All exchange cells in one layer obey a single bit of an n-bit control word. As the control word steps through all N values, every input lane is routed to every output lane exactly once. This is the schedule needed to transpose a matrix that is spread across N sources and N sinks: source i sends its element for sink j in the cycle where the control word equals i XOR j.

Each layer can be followed by a register, in which case the control word moves down the pipeline with its data. A parameter can also drop the shuffle after the last layer, which removes one wiring layer and leaves the outputs in a fixed rotated order. The control word may take a new value in every clock cycle.

Top module: `xor_corner_turner`

## Requirements
- R1: With PIPELINED=1, lanes_out is all zero while rst_n is low. It stays zero until LOG2 N rising edges have passed with rst_n high.
- R2: With KEEP_LAST_SHUFFLE=1, the word on input lane i appears on output lane i XOR c, where c is the control word that came with it.
- R3: With KEEP_LAST_SHUFFLE=0, the word on input lane i appears on output lane rotr(i XOR c). Here rotr moves index bit 0 to bit n-1 and shifts the other bits down by one.
- R4: Every exchange cell in a layer shares one control bit. Layer l uses bit (n-l) mod n of the control word. When that bit is 1, the cell swaps lanes 2k and 2k+1. A one-hot control word therefore flips exactly the matching bit of every lane index.
- R5: With PIPELINED=1, a result appears on lanes_out after exactly LOG2 N rising edges. With PIPELINED=0, it appears in the same cycle.
- R6: The control word may change in every cycle. Each result is routed by the control word that was presented together with its data.
- R7: For every control value, the outputs are a collision-free permutation of the inputs. Over all N control values, each input lane reaches each output lane exactly once.
- R8: With c = 0 and the last shuffle kept, the network is the identity, because n perfect shuffles bring every lane index back to its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| ctrl_in | input | LOG2 N | Control word c that selects the XOR permutation |
| lanes_in | input | LANES*DATA_W | Input lanes; lane i occupies bits [i*DATA_W +: DATA_W] |
| lanes_out | output | LANES*DATA_W | Output lanes in the same packing |

## Verification
The pipelined instance produces its result three rising edges after the inputs are driven (LOG2 8 layers). The combinational instance has no latency. Inputs change at falling edges. The pipelined output is compared at the third falling edge after a drive, against a history of the control words and data tags applied, and the combinational output is read 1 ns after each drive. The latency test holds one pattern, switches to another, and confirms that the old routing is still visible at the first and second falling edges and that the new one appears at the third. The reset test confirms zeros up to that same third edge.

// File: rtl/ctn_pkg.sv
`timescale 1ns/1ps
package ctn_pkg;
    // destination lane of lane j under a perfect shuffle of `lanes` lanes
    function automatic int unsigned shuffle_dst(int unsigned j, int unsigned lanes);
        return (2 * j < lanes) ? 2 * j : 2 * j - lanes + 1;
    endfunction

    // control bit consumed by a layer so that the full network yields i XOR c
    function automatic int unsigned layer_ctrl_bit(int unsigned layer, int unsigned n);
        return (n - layer) % n;
    endfunction

    // rotate an n-bit index right by one
    function automatic int unsigned rotr_idx(int unsigned v, int unsigned n);
        return (v >> 1) | ((v & 1) << (n - 1));
    endfunction
endpackage

// File: rtl/ctn_swap_col.sv
`timescale 1ns/1ps
module ctn_swap_col #(
    parameter int LANES  = 8,
    parameter int DATA_W = 8
) (
    input  logic                      sel,
    input  logic [LANES*DATA_W-1:0]   din,
    output logic [LANES*DATA_W-1:0]   dout
);
    localparam int PAIRS = LANES / 2;

    for (genvar k = 0; k < PAIRS; k++) begin : g_cell
        localparam int LO = (2 * k) * DATA_W;
        localparam int HI = (2 * k + 1) * DATA_W;
        assign dout[LO +: DATA_W] = sel ? din[HI +: DATA_W] : din[LO +: DATA_W];
        assign dout[HI +: DATA_W] = sel ? din[LO +: DATA_W] : din[HI +: DATA_W];
    end
endmodule

// File: rtl/ctn_shuffle.sv
`timescale 1ns/1ps
module ctn_shuffle #(
    parameter int LANES  = 8,
    parameter int DATA_W = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic [LANES*DATA_W-1:0] din,
    output logic [LANES*DATA_W-1:0] dout
);
    for (genvar j = 0; j < LANES; j++) begin : g_wire
        localparam int DST = ENABLE ? int'(ctn_pkg::shuffle_dst(j, LANES)) : j;
        assign dout[DST*DATA_W +: DATA_W] = din[j*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/ctn_stage.sv
`timescale 1ns/1ps
module ctn_stage #(
    parameter int LANES      = 8,
    parameter int DATA_W     = 8,
    parameter int CTRL_W     = 3,
    parameter int LAYER      = 0,
    parameter bit DO_SHUFFLE = 1'b1,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CTRL_W-1:0]       ctrl_in,
    input  logic [LANES*DATA_W-1:0] din,
    output logic [CTRL_W-1:0]       ctrl_out,
    output logic [LANES*DATA_W-1:0] dout
);
    localparam int VEC_W   = LANES * DATA_W;
    localparam int SEL_BIT = int'(ctn_pkg::layer_ctrl_bit(LAYER, CTRL_W));

    logic [VEC_W-1:0] swapped;
    logic [VEC_W-1:0] shuffled;

    ctn_swap_col #(.LANES(LANES), .DATA_W(DATA_W)) u_swap (
        .sel  (ctrl_in[SEL_BIT]),
        .din  (din),
        .dout (swapped)
    );

    ctn_shuffle #(.LANES(LANES), .DATA_W(DATA_W), .ENABLE(DO_SHUFFLE)) u_shuf (
        .din  (swapped),
        .dout (shuffled)
    );

    if (REGISTERED) begin : g_reg
        typedef struct packed {
            logic [VEC_W-1:0]  data;
            logic [CTRL_W-1:0] ctrl;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d.data = shuffled;
            st_d.ctrl = ctrl_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign dout     = st_q.data;
        assign ctrl_out = st_q.ctrl;
    end else begin : g_comb
        assign dout     = shuffled;
        assign ctrl_out = ctrl_in;
    end

    // ---------------- assertions ----------------
    logic [DATA_W-1:0] fold_in, fold_mid;
    always_comb begin
        fold_in  = '0;
        fold_mid = '0;
        for (int k = 0; k < LANES; k++) begin
            fold_in  = fold_in  ^ din[k*DATA_W +: DATA_W];
            fold_mid = fold_mid ^ shuffled[k*DATA_W +: DATA_W];
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            AST_XOR_KEEP: assert (fold_in == fold_mid) else $error("layer lost data"); // R7
            for (int k = 0; k < LANES; k++) begin
                int unsigned dst;
                dst = int'(k) ^ int'(ctrl_in[SEL_BIT]);
                if (DO_SHUFFLE) dst = ctn_pkg::shuffle_dst(dst, LANES);
                AST_LANE_MAP: assert (shuffled[dst*DATA_W +: DATA_W] == din[k*DATA_W +: DATA_W])
                    else $error("layer routed lane %0d wrongly", k); // R4
            end
        end
    end
endmodule

// File: rtl/xor_corner_turner.sv
`timescale 1ns/1ps
module xor_corner_turner #(
    parameter int LANES             = 8,
    parameter int DATA_W            = 8,
    parameter bit PIPELINED         = 1'b1,
    parameter bit KEEP_LAST_SHUFFLE = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(LANES)-1:0]      ctrl_in,
    input  logic [LANES*DATA_W-1:0]       lanes_in,
    output logic [LANES*DATA_W-1:0]       lanes_out
);
    localparam int CTRL_W = $clog2(LANES);
    localparam int VEC_W  = LANES * DATA_W;
    localparam int LAT    = PIPELINED ? CTRL_W : 0;

    logic [VEC_W-1:0]  lane_bus [0:CTRL_W];
    logic [CTRL_W-1:0] ctrl_bus [0:CTRL_W];

    assign lane_bus[0] = lanes_in;
    assign ctrl_bus[0] = ctrl_in;

    for (genvar l = 0; l < CTRL_W; l++) begin : g_layer
        localparam bit SHUF = (l < CTRL_W - 1) || KEEP_LAST_SHUFFLE;
        ctn_stage #(
            .LANES(LANES), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LAYER(l),
            .DO_SHUFFLE(SHUF), .REGISTERED(PIPELINED)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_in  (ctrl_bus[l]),
            .din      (lane_bus[l]),
            .ctrl_out (ctrl_bus[l+1]),
            .dout     (lane_bus[l+1])
        );
    end

    assign lanes_out = lane_bus[CTRL_W];

    // ---------------- assertions ----------------
    if (PIPELINED) begin : g_chk_pipe
        localparam int FILL_W = $clog2(LAT + 1);
        logic [FILL_W-1:0] fill_d, fill_q;

        always_comb begin
            fill_d = (fill_q == FILL_W'(LAT)) ? fill_q : fill_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fill_q <= '0;
            else        fill_q <= fill_d;
        end

        AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_q < FILL_W'(LAT)) |-> (lanes_out == '0 && ctrl_bus[CTRL_W] == '0)); // R1
    end else begin : g_chk_comb
        always @(posedge clk) begin
            if (rst_n) begin
                for (int k = 0; k < LANES; k++) begin
                    int unsigned dst;
                    dst = int'(k) ^ int'(ctrl_bus[CTRL_W]);
                    if (!KEEP_LAST_SHUFFLE) dst = ctn_pkg::rotr_idx(dst, CTRL_W);
                    AST_XOR_MAP: assert (lanes_out[dst*DATA_W +: DATA_W] == lanes_in[k*DATA_W +: DATA_W])
                        else $error("lane %0d misrouted", k); // R2
                end
            end
        end
    end
endmodule

// File: tb/xor_corner_turner_tb.sv
`timescale 1ns/1ps
module xor_corner_turner_tb_top;
    localparam int N   = 8;
    localparam int W   = 8;
    localparam int CW  = 3;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0]  ctrl = '0;
    logic [N*W-1:0] din = '0;
    logic [N*W-1:0] a_out, b_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xor_corner_turner #(.LANES(N), .DATA_W(W), .PIPELINED(1'b1), .KEEP_LAST_SHUFFLE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl), .lanes_in(din), .lanes_out(a_out)
    );

    xor_corner_turner #(.LANES(N), .DATA_W(W), .PIPELINED(1'b0), .KEEP_LAST_SHUFFLE(1'b0)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl), .lanes_in(din), .lanes_out(b_out)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rotr3(int v);
        return ((v >> 1) | ((v & 1) << (CW - 1))) & (N - 1);
    endfunction

    function automatic logic [N*W-1:0] make_vec(int tag);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'((tag << 3) | i);
        return v;
    endfunction

    // compare every lane of one output against the routing rule
    task automatic check_route(input string req, input logic [N*W-1:0] got, input int c, input int tag, input bit trim);
        for (int i = 0; i < N; i++) begin
            int dst;
            logic [W-1:0] exp;
            dst = i ^ c;
            if (trim) dst = rotr3(dst);
            exp = W'((tag << 3) | i);
            check(got[dst*W +: W] == exp, req, 64'(got[dst*W +: W]), 64'(exp));
        end
    endtask

    task automatic drive(input int c, input int tag);
        ctrl = CW'(c);
        din  = make_vec(tag);
    endtask

    task automatic t_reset;
        drive(5, 9);
        repeat (3) @(negedge clk);
        check(a_out == '0, "R1 zero in reset", 64'(a_out), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(a_out == '0, "R1 zero one edge after reset", 64'(a_out), 64'h0);
        @(negedge clk);
        check(a_out == '0, "R1 zero two edges after reset", 64'(a_out), 64'h0);
        @(negedge clk);
        check_route("R5 first result at edge three", a_out, 5, 9, 1'b0);
    endtask

    task automatic t_sweep;
        int hits_a [N][N];
        int hits_b [N][N];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin hits_a[i][j] = 0; hits_b[i][j] = 0; end
        for (int c = 0; c < N; c++) begin
            logic [N-1:0] seen;
            string req;
            @(negedge clk);
            drive(c, 16 + c);
            #1;
            check_route("R3 trimmed route", b_out, c, 16 + c, 1'b1);
            for (int j = 0; j < N; j++) hits_b[b_out[j*W +: 3]][j]++;
            repeat (LAT) @(negedge clk);
            req = ($countones(c) == 1) ? "R4 one-hot control" : "R2 xor route";
            check_route(req, a_out, c, 16 + c, 1'b0);
            seen = '0;
            for (int j = 0; j < N; j++) begin
                seen[a_out[j*W +: 3]] = 1'b1;
                hits_a[a_out[j*W +: 3]][j]++;
            end
            check(seen == '1, "R7 no collision", 64'(seen), 64'hff);
            if (c == 0) check(a_out == din, "R8 identity at zero", 64'(a_out), 64'(din));
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                check(hits_a[i][j] == 1, "R7 full coverage", 64'(hits_a[i][j]), 64'd1);
                check(hits_b[i][j] == 1, "R7 full coverage trimmed", 64'(hits_b[i][j]), 64'd1);
            end
    endtask

    task automatic t_stream;
        int c_hist [32];
        for (int m = 0; m < 24; m++) begin
            @(negedge clk);
            if (m >= LAT) check_route("R6 per-cycle control", a_out, c_hist[m-LAT], 40 + m - LAT, 1'b0);
            c_hist[m] = (m * 5 + 3) % N;
            drive(c_hist[m], 40 + m);
            #1;
            check_route("R6 per-cycle control trimmed", b_out, c_hist[m], 40 + m, 1'b1);
        end
    endtask

    task automatic t_latency;
        @(negedge clk);
        drive(5, 30);
        repeat (4) @(negedge clk);
        drive(2, 31);
        #1;
        check_route("R5 comb same cycle", b_out, 2, 31, 1'b1);
        @(negedge clk);
        check_route("R5 old result edge one", a_out, 5, 30, 1'b0);
        @(negedge clk);
        check_route("R5 old result edge two", a_out, 5, 30, 1'b0);
        @(negedge clk);
        check_route("R5 new result edge three", a_out, 2, 31, 1'b0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_stream();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule